// File: doc/BRIEF.md
# Programmable-Priority Channel Arbiter with Error Status

This block chooses which of up to `NUM_CH` DMA channels is served next. Each channel holds a priority level that software writes through a small address/data port. Among the channels that are requesting, the one with the numerically largest level wins. If several requesting channels share that top level, the lowest channel index wins, so the result is always deterministic.

The grant is registered and only changes while the engine reports no transfer in progress, so a service that is running is never preempted. The grant appears as a one-hot vector, a valid flag and a channel number. The data engine uses these to route its handshake acknowledge and error interrupt to the selected channel.

Alongside arbitration, the block watches the whole priority set for repeated values. It raises a global configuration-error flag in any cycle where such a repeat exists and at least one channel is requesting. That flag carries no channel number. Descriptor errors reported by the engine are charged to the currently granted channel, and that channel's number is latched into an error status register. The register also has a valid bit, which the priority error sets as well and a write-one-to-clear strobe resets.

Top module: `chan_prio_arbiter`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `gnt_o` is zero and `gnt_vld_o`, `prio_err_o` and `err_vld_o` are low. Reset loads the priority of channel i with the value i (modulo 2^PRIO_W).
- R2: If `busy_i` is low at a rising edge and `req_i` is nonzero, then after that edge `gnt_vld_o` is high. `gnt_ch_o` then names the requesting channel with the largest priority, and `gnt_o` has only bit `gnt_ch_o` set.
- R3: If several requesting channels share the largest priority, the one with the smallest index is granted.
- R4: While `busy_i` is high at a rising edge, `gnt_o`, `gnt_vld_o` and `gnt_ch_o` keep their values, whatever `req_i` or the priorities do.
- R5: If `busy_i` is low and `req_i` is zero at an edge, `gnt_vld_o` is low and `gnt_o` is zero after that edge.
- R6: A cycle with `cfg_we_i` high stores `cfg_wdata_i` (PRIO_W bits) as the priority of channel `cfg_addr_i`. Arbitration at the next edge and later uses the new value.
- R7: After each edge, `prio_err_o` is high exactly when, at that edge, two or more channels held equal priorities and `req_i` was nonzero.
- R8: When `desc_err_i` is high at an edge while `gnt_vld_o` is high, `err_vld_o` is set and `err_ch_o` takes the value of `gnt_ch_o`. When `gnt_vld_o` is low, `desc_err_i` is ignored.
- R9: Any edge at which the condition of R7 holds also sets `err_vld_o`, and it leaves `err_ch_o` unchanged.
- R10: `err_clr_i` high at an edge clears `err_vld_o`, unless an error that sets it arrives at the same edge, in which case the bit stays set.
- R11: A later descriptor error overwrites `err_ch_o` with the newly granted channel, even if `err_vld_o` is still set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NUM_CH | Service request per channel |
| busy_i | input | 1 | Transfer in progress; freezes the grant |
| cfg_we_i | input | 1 | Priority write enable |
| cfg_addr_i | input | CH_W | Channel whose priority is written |
| cfg_wdata_i | input | PRIO_W | Priority value to write |
| desc_err_i | input | 1 | Descriptor error on the granted channel |
| err_clr_i | input | 1 | Write-one-to-clear of the error valid bit |
| gnt_o | output | NUM_CH | One-hot grant |
| gnt_vld_o | output | 1 | Grant is valid |
| gnt_ch_o | output | CH_W | Granted channel number |
| prio_err_o | output | 1 | Global duplicate-priority error |
| err_vld_o | output | 1 | Error status valid |
| err_ch_o | output | CH_W | Channel number of the last descriptor error |

## Verification
Two functions can act on the error valid bit in the same cycle: a clear strobe, and a new error (either a descriptor error on the granted channel or a duplicate-priority condition). The bench provokes the collision in two ways. First, it holds a grant with `busy_i` and pulses `err_clr_i` and `desc_err_i` together. Second, it pulses the clear while duplicate priorities and an active request are present. In both cases the valid bit must remain set and the channel field must reflect the rule for that error type. A lone clear, issued afterwards, must drop the bit.

// File: rtl/chan_prio_arbiter_pkg.sv
package chan_prio_arbiter_pkg;

  // Kind of error event presented to the status register in one cycle.
  typedef enum logic [1:0] {
    EV_NONE = 2'b00,
    EV_DESC = 2'b01,
    EV_PRIO = 2'b10,
    EV_BOTH = 2'b11
  } err_evt_e;

  function automatic err_evt_e make_evt(input logic desc, input logic prio);
    return err_evt_e'({prio, desc});
  endfunction

endpackage

// File: rtl/parr_prio_regs.sv
module parr_prio_regs #(
  parameter int NUM_CH = 16,
  parameter int PRIO_W = 4,
  parameter int CH_W   = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [CH_W-1:0]          addr,
  input  logic [PRIO_W-1:0]        wdata,
  output logic [NUM_CH*PRIO_W-1:0] prio_flat,
  output logic                     dup_o
);

  localparam int NPAIR = NUM_CH * NUM_CH;

  logic [NPAIR-1:0] pair_eq;

  // One register per channel; the reset value is the channel index.
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst)
        prio_flat[c*PRIO_W +: PRIO_W] <= PRIO_W'(c);
      else if (we && (addr == CH_W'(c)))
        prio_flat[c*PRIO_W +: PRIO_W] <= wdata;
    end
  end

  // Pairwise equality over the upper triangle only.
  for (genvar i = 0; i < NUM_CH; i++) begin : g_row
    for (genvar j = 0; j < NUM_CH; j++) begin : g_col
      if (j > i) begin : g_cmp
        assign pair_eq[i*NUM_CH + j] =
          (prio_flat[i*PRIO_W +: PRIO_W] == prio_flat[j*PRIO_W +: PRIO_W]);
      end else begin : g_zero
        assign pair_eq[i*NUM_CH + j] = 1'b0;
      end
    end
  end

  assign dup_o = |pair_eq;

endmodule

// File: rtl/parr_select.sv
module parr_select #(
  parameter int NUM_CH = 16,
  parameter int PRIO_W = 4,
  parameter int CH_W   = 4
) (
  input  logic [NUM_CH-1:0]        req,
  input  logic [NUM_CH*PRIO_W-1:0] prio_flat,
  output logic                     win_vld,
  output logic [CH_W-1:0]          win_ch,
  output logic [NUM_CH-1:0]        win_onehot
);

  logic [PRIO_W-1:0] best_p;

  // Scan from the top index down; ">=" lets a lower index take a tie.
  always_comb begin
    win_vld = 1'b0;
    win_ch  = '0;
    best_p  = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (req[i] && (!win_vld || prio_flat[i*PRIO_W +: PRIO_W] >= best_p)) begin
        win_vld = 1'b1;
        win_ch  = CH_W'(i);
        best_p  = prio_flat[i*PRIO_W +: PRIO_W];
      end
    end
    win_onehot = win_vld ? (NUM_CH'(1) << win_ch) : '0;
  end

endmodule

// File: rtl/parr_err_status.sv
module parr_err_status
  import chan_prio_arbiter_pkg::*;
#(
  parameter int CH_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  err_evt_e        evt,
  input  logic [CH_W-1:0] evt_ch,
  input  logic            clr,
  output logic            vld_o,
  output logic [CH_W-1:0] ch_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o <= 1'b0;
      ch_o  <= '0;
    end else begin
      // A new error outranks a clear arriving in the same cycle.
      if (evt != EV_NONE)
        vld_o <= 1'b1;
      else if (clr)
        vld_o <= 1'b0;
      // Only descriptor errors carry a channel number.
      if (evt == EV_DESC || evt == EV_BOTH)
        ch_o <= evt_ch;
    end
  end

endmodule

// File: rtl/chan_prio_arbiter.sv
module chan_prio_arbiter
  import chan_prio_arbiter_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int PRIO_W = 4,
  parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] req_i,
  input  logic              busy_i,
  input  logic              cfg_we_i,
  input  logic [CH_W-1:0]   cfg_addr_i,
  input  logic [PRIO_W-1:0] cfg_wdata_i,
  input  logic              desc_err_i,
  input  logic              err_clr_i,
  output logic [NUM_CH-1:0] gnt_o,
  output logic              gnt_vld_o,
  output logic [CH_W-1:0]   gnt_ch_o,
  output logic              prio_err_o,
  output logic              err_vld_o,
  output logic [CH_W-1:0]   err_ch_o
);

  logic [NUM_CH*PRIO_W-1:0] prio_flat;
  logic                     dup;
  logic                     win_vld;
  logic [CH_W-1:0]          win_ch;
  logic [NUM_CH-1:0]        win_onehot;
  logic                     cpe_now;
  err_evt_e                 evt;

  parr_prio_regs #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W), .CH_W(CH_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .we        (cfg_we_i),
    .addr      (cfg_addr_i),
    .wdata     (cfg_wdata_i),
    .prio_flat (prio_flat),
    .dup_o     (dup)
  );

  parr_select #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W), .CH_W(CH_W)) u_sel (
    .req        (req_i),
    .prio_flat  (prio_flat),
    .win_vld    (win_vld),
    .win_ch     (win_ch),
    .win_onehot (win_onehot)
  );

  // Grant register: reloads only while no transfer is running.
  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_o     <= '0;
      gnt_vld_o <= 1'b0;
      gnt_ch_o  <= '0;
    end else if (!busy_i) begin
      gnt_o     <= win_onehot;
      gnt_vld_o <= win_vld;
      gnt_ch_o  <= win_ch;
    end
  end

  assign cpe_now = dup && (|req_i);

  always_ff @(posedge clk) begin
    if (rst) prio_err_o <= 1'b0;
    else     prio_err_o <= cpe_now;
  end

  assign evt = make_evt(desc_err_i && gnt_vld_o, cpe_now);

  parr_err_status #(.CH_W(CH_W)) u_err (
    .clk    (clk),
    .rst    (rst),
    .evt    (evt),
    .evt_ch (gnt_ch_o),
    .clr    (err_clr_i),
    .vld_o  (err_vld_o),
    .ch_o   (err_ch_o)
  );

endmodule

// File: rtl/chan_prio_arbiter_chk.sv
module chan_prio_arbiter_chk #(
  parameter int NUM_CH = 16,
  parameter int CH_W   = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              busy_i,
  input logic              desc_err_i,
  input logic              err_clr_i,
  input logic [NUM_CH-1:0] gnt_o,
  input logic              gnt_vld_o,
  input logic [CH_W-1:0]   gnt_ch_o,
  input logic              prio_err_o,
  input logic              err_vld_o,
  input logic [CH_W-1:0]   err_ch_o
);

  p_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt_o));

  p_vld_match_r2: assert property (@(posedge clk) disable iff (rst)
    gnt_vld_o == (gnt_o != '0));

  p_ch_match_r2: assert property (@(posedge clk) disable iff (rst)
    gnt_vld_o |-> gnt_o[gnt_ch_o]);

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(busy_i)) |->
      ($stable(gnt_o) && $stable(gnt_vld_o) && $stable(gnt_ch_o)));

  p_err_capture_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(desc_err_i && gnt_vld_o)) |->
      (err_vld_o && err_ch_o == $past(gnt_ch_o)));

  p_cpe_sets_r9: assert property (@(posedge clk) disable iff (rst)
    prio_err_o |-> err_vld_o);

  p_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(err_clr_i && !(desc_err_i && gnt_vld_o)) && !prio_err_o)
      |-> !err_vld_o);

endmodule

bind chan_prio_arbiter chan_prio_arbiter_chk #(.NUM_CH(NUM_CH), .CH_W(CH_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .busy_i     (busy_i),
  .desc_err_i (desc_err_i),
  .err_clr_i  (err_clr_i),
  .gnt_o      (gnt_o),
  .gnt_vld_o  (gnt_vld_o),
  .gnt_ch_o   (gnt_ch_o),
  .prio_err_o (prio_err_o),
  .err_vld_o  (err_vld_o),
  .err_ch_o   (err_ch_o)
);

// File: tb/chan_prio_arbiter_tb_top.sv
`timescale 1ns/1ps
module chan_prio_arbiter_tb_top;

  localparam int NUM_CH = 16;
  localparam int PRIO_W = 4;
  localparam int CH_W   = 4;

  logic              clk = 1'b0;
  logic              rst;
  logic [NUM_CH-1:0] req_i;
  logic              busy_i;
  logic              cfg_we_i;
  logic [CH_W-1:0]   cfg_addr_i;
  logic [PRIO_W-1:0] cfg_wdata_i;
  logic              desc_err_i;
  logic              err_clr_i;
  logic [NUM_CH-1:0] gnt_o;
  logic              gnt_vld_o;
  logic [CH_W-1:0]   gnt_ch_o;
  logic              prio_err_o;
  logic              err_vld_o;
  logic [CH_W-1:0]   err_ch_o;

  int n_chk  = 0;
  int n_fail = 0;
  logic [PRIO_W-1:0] shadow [NUM_CH];

  always #4 clk = ~clk;  // 125 MHz

  chan_prio_arbiter #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W)) dut_i (.*);

  // {req[15:0], expected channel[3:0]} with reset priorities (prio i = i).
  localparam logic [19:0] VEC [10] = '{
    {16'h0001, 4'h0}, {16'h8000, 4'hF}, {16'h00F0, 4'h7}, {16'h0A0A, 4'hB},
    {16'hFFFF, 4'hF}, {16'h0100, 4'h8}, {16'h0003, 4'h1}, {16'h4004, 4'hE},
    {16'h0000, 4'h0}, {16'h1200, 4'hC}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void ref_win(input logic [NUM_CH-1:0] r, output bit v,
                                  output int ch);
    v = 0; ch = 0;
    for (int i = 0; i < NUM_CH; i++)
      if (r[i] && (!v || shadow[i] > shadow[ch])) begin v = 1; ch = i; end
  endfunction

  function automatic bit ref_dup();
    for (int i = 0; i < NUM_CH; i++)
      for (int j = i + 1; j < NUM_CH; j++)
        if (shadow[i] == shadow[j]) return 1;
    return 0;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1; req_i = '0; busy_i = 0; cfg_we_i = 0; cfg_addr_i = '0;
    cfg_wdata_i = '0; desc_err_i = 0; err_clr_i = 0;
    for (int i = 0; i < NUM_CH; i++) shadow[i] = PRIO_W'(i);
    @(negedge clk); @(negedge clk);
    rst = 0;
  endtask

  task automatic set_prio(input int ch, input int p);
    cfg_we_i = 1; cfg_addr_i = CH_W'(ch); cfg_wdata_i = PRIO_W'(p);
    @(negedge clk);
    cfg_we_i = 0;
    shadow[ch] = PRIO_W'(p);
  endtask

  // Apply a request for one edge, then compare against the model.
  task automatic arb(input logic [NUM_CH-1:0] r, input string tag);
    bit v; int ch; bit d;
    ref_win(r, v, ch);
    d = ref_dup() && (r != '0);
    req_i = r;
    @(negedge clk);
    chk(gnt_vld_o == v, {tag, " vld"}, gnt_vld_o, v);
    if (v) begin
      chk(gnt_ch_o == CH_W'(ch), {tag, " ch"}, gnt_ch_o, ch);
      chk(gnt_o == (NUM_CH'(1) << ch), {tag, " onehot"}, gnt_o, NUM_CH'(1) << ch);
    end else begin
      chk(gnt_o == '0, {tag, " none"}, gnt_o, 0);
    end
    chk(prio_err_o == d, "R7 prio_err", prio_err_o, d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    do_reset();
    // R1: state right after reset
    chk(gnt_o == '0 && !gnt_vld_o, "R1 grant after reset", gnt_o, 0);
    chk(!prio_err_o && !err_vld_o, "R1 flags after reset", {prio_err_o, err_vld_o}, 0);

    // R2, R5: table of request patterns at reset priorities
    for (int k = 0; k < 10; k++) begin
      arb(VEC[k][19:4], (VEC[k][19:4] == '0) ? "R5 idle" : "R2 table");
      if (VEC[k][19:4] != '0)
        chk(gnt_ch_o == VEC[k][3:0], "R2 table expected", gnt_ch_o, VEC[k][3:0]);
    end

    // R6 + R3: reprogram to make channels 3 and 9 tie at the top
    set_prio(3, 15);
    set_prio(9, 15);
    set_prio(15, 2);
    arb(16'h8208, "R3 tie low index");
    chk(gnt_ch_o == 4'd3, "R3 tie winner", gnt_ch_o, 3);
    chk(prio_err_o, "R7 dup with request", prio_err_o, 1);
    chk(err_vld_o, "R9 cpe sets valid", err_vld_o, 1);
    chk(err_ch_o == 4'd0, "R9 channel untouched", err_ch_o, 0);
    arb(16'h0000, "R5 R7 no request");
    chk(!prio_err_o, "R7 dup without request", prio_err_o, 0);
    set_prio(0, 14);
    arb(16'h8001, "R6 new priority used");

    // R10 collision with cpe: clear together with duplicate + request
    err_clr_i = 1; req_i = 16'h0200;
    @(negedge clk);
    err_clr_i = 0;
    chk(err_vld_o, "R10 cpe beats clear", err_vld_o, 1);

    // Random patterns against the model, including duplicates
    for (int k = 0; k < 60; k++) begin
      if (k % 3 == 0) set_prio($urandom % NUM_CH, $urandom % 6);
      arb(NUM_CH'($urandom), "R2 R3 random");
    end

    // Error register tests on unique priorities
    do_reset();
    arb(16'h0020, "R2 grant ch5");
    busy_i = 1;
    req_i = 16'h8000;
    @(negedge clk);
    chk(gnt_ch_o == 4'd5, "R4 hold while busy", gnt_ch_o, 5);
    chk(gnt_o == 16'h0020, "R4 onehot held", gnt_o, 16'h0020);
    desc_err_i = 1;
    @(negedge clk);
    desc_err_i = 0;
    chk(err_vld_o && err_ch_o == 4'd5, "R8 capture ch", {err_vld_o, err_ch_o}, {1'b1, 4'd5});
    err_clr_i = 1;
    @(negedge clk);
    err_clr_i = 0;
    chk(!err_vld_o, "R10 clear alone", err_vld_o, 0);
    chk(err_ch_o == 4'd5, "R10 clear keeps channel", err_ch_o, 5);
    err_clr_i = 1; desc_err_i = 1;
    @(negedge clk);
    err_clr_i = 0; desc_err_i = 0;
    chk(err_vld_o, "R10 error beats clear", err_vld_o, 1);
    busy_i = 0;
    arb(16'h0400, "R2 grant ch10");
    desc_err_i = 1;
    @(negedge clk);
    desc_err_i = 0;
    chk(err_ch_o == 4'd10, "R11 overwrite channel", err_ch_o, 10);
    err_clr_i = 1;
    @(negedge clk);
    err_clr_i = 0;
    arb(16'h0000, "R5 drop grant");
    desc_err_i = 1;
    @(negedge clk);
    desc_err_i = 0;
    chk(!err_vld_o, "R8 ignored without grant", err_vld_o, 0);
    chk(err_ch_o == 4'd10, "R8 channel unchanged", err_ch_o, 10);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule